// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block holds the software-interrupt state of a multi-core interrupt controller. A processor raises a software interrupt by a single 32-bit word write: the low ten bits name the interrupt, and a two-bit filter field picks the destination cores. The filter can use an explicit core list, every core except the writer, the writer alone, or every core. For each destination core and interrupt number, the block keeps a bitmask that records which source cores raised it. The interrupt stays pending on that core while any source remains.

A core acknowledges one interrupt number at a time. The block returns a 13-bit code that holds the interrupt number and, above it, the lowest-numbered source core. It then clears that source bit. The interrupt stays pending until every source has been served. Two byte-wide banks let the writing core set or clear source bits in its own cells directly. Choosing which interrupt a core acknowledges (priority arbitration) and decoding the bus both happen outside this block.

Top module: `sgi_dispatch`

## Requirements
- R1: A send operation (`wr_kind` = 0) takes the interrupt number from `wr_data[9:0]`. A number at or above `NUM_SGI` (including any with bits 9:4 nonzero) changes no state.
- R2: With filter `wr_data[25:24]` = 0, the destinations are the cores whose bits are set in `wr_data[23:16]`. Bit k selects core k, and list bits at or above `NUM_CPU` select nothing.
- R3: Filter 1 selects every core except the writer `wr_cpu`.
- R4: Filter 2 selects only the writer, and filter 3 selects every core.
- R5: For each selected core, a send ORs the writer's bit into that core's source mask for the interrupt and marks it pending there. Sources from several writers accumulate.
- R6: `ack_val` for core c shows `{src[2:0], id[9:0]}` for interrupt `ack_sel` of core c, where src is the lowest set source bit. An acknowledge (`ack_req[c]`) clears that bit. The interrupt stays pending while other source bits remain.
- R7: Acknowledging the last source bit clears the pending state.
- R8: When the selected interrupt is not pending, `ack_val` is 13'h3FF, and an acknowledge changes nothing.
- R9: A clear-bank write (`wr_kind` = 2) clears the bits of `wr_data[NUM_CPU-1:0]` in the writer's source mask for interrupt `wr_sel`. Pending drops only if the mask becomes empty. `wr_kind` = 3 does nothing.
- R10: A set-bank write (`wr_kind` = 1) ORs `wr_data[NUM_CPU-1:0]` into the writer's mask for `wr_sel` and marks it pending, even when the data is zero. Acknowledging a pending interrupt with an empty mask returns source 0 and clears it.
- R11: Every write takes effect at the next clock edge. If an acknowledge and a write hit the same core and interrupt in one cycle, the acknowledge is served from the old state and the write is dropped for that cell only.
- R12: After reset, no interrupt is pending and every `ack_val` reads 13'h3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 send, 1 set bank, 2 clear bank, 3 none |
| wr_cpu | input | CPU_W | Number of the writing core |
| wr_sel | input | SEL_W | Interrupt number for bank writes |
| wr_data | input | 32 | Write data |
| ack_req | input | NUM_CPU | Per-core acknowledge strobe |
| ack_sel | input | NUM_CPU*SEL_W | Per-core interrupt number to acknowledge |
| ack_val | output | NUM_CPU*13 | Per-core acknowledge code |
| pend_out | output | NUM_CPU*NUM_SGI | Pending bit, index core*NUM_SGI+id |

## Verification
The assertions assume that `wr_cpu` always names an existing core and that `wr_kind` carries one operation per cycle, so a cell never sees a set and a clear together. The stimulus drives only core numbers 0 to 3 with the default four cores, and it issues one write per cycle. Acknowledges on several cores may share a cycle with a write, and that includes the same-cell collision.

// File: rtl/sgi_disp_pkg.sv
package sgi_disp_pkg;
   localparam int ID_W      = 10;
   localparam int SRC_W     = 3;
   localparam int CODE_W    = SRC_W + ID_W;
   localparam logic [CODE_W-1:0] SPURIOUS = 13'h03FF;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_ALL    = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      OP_SEND = 2'd0,
      OP_SETB = 2'd1,
      OP_CLRB = 2'd2,
      OP_NONE = 2'd3
   } op_e;
endpackage

// File: rtl/sgi_target_dec.sv
module sgi_target_dec
   import sgi_disp_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int CPU_W   = 2
) (
   input  logic [1:0]         flt,
   input  logic [NUM_CPU-1:0] list,
   input  logic [CPU_W-1:0]   writer,
   output logic [NUM_CPU-1:0] targets
);
   logic [NUM_CPU-1:0] self_oh;
   logic [NUM_CPU-1:0] all_cpu;

   assign self_oh = NUM_CPU'(1) << writer;
   assign all_cpu = '1;

   always_comb begin
      unique case (flt_e'(flt))
         FLT_LIST:   targets = list;
         FLT_OTHERS: targets = all_cpu & ~self_oh;
         FLT_SELF:   targets = self_oh;
         default:    targets = all_cpu;
      endcase
   end
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell
   import sgi_disp_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [NUM_CPU-1:0] set_bits,
   input  logic               clr_en,
   input  logic [NUM_CPU-1:0] clr_bits,
   input  logic               ack_en,
   output logic               pend_q,
   output logic [SRC_W-1:0]   src_idx
);
   logic [NUM_CPU-1:0] mask_q, mask_d, low_oh;
   logic               pend_d, ack_take;

   assign low_oh   = mask_q & (~mask_q + NUM_CPU'(1));
   assign ack_take = ack_en & pend_q;

   always_comb begin
      src_idx = '0;
      for (int k = NUM_CPU - 1; k >= 0; k--) begin
         if (mask_q[k]) src_idx = SRC_W'(k);
      end
   end

   always_comb begin
      mask_d = mask_q;
      pend_d = pend_q;
      if (ack_take) begin
         mask_d = mask_q & ~low_oh;
         pend_d = |mask_d;
      end else if (set_en) begin
         mask_d = mask_q | set_bits;
         pend_d = 1'b1;
      end else if (clr_en) begin
         mask_d = mask_q & ~clr_bits;
         pend_d = pend_q & (|mask_d);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         pend_q <= 1'b0;
      end else begin
         mask_q <= mask_d;
         pend_q <= pend_d;
      end
   end

   // R6
   ack_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> (mask_q & $past(low_oh)) == '0);
   // R5
   set_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !ack_take) |=> pend_q && ((mask_q & $past(set_bits)) == $past(set_bits)));
   // R9
   clr_empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && !ack_take && ((mask_q & ~clr_bits) == '0)) |=> !pend_q);
   // R11
   no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en || ack_take) |=> (mask_q & ~$past(mask_q)) == '0);
   // R8
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && !pend_q && !set_en && !clr_en) |=> $stable(mask_q) && !pend_q);
endmodule

// File: rtl/sgi_ack_enc.sv
module sgi_ack_enc
   import sgi_disp_pkg::*;
#(
   parameter int NUM_SGI = 16,
   parameter int SEL_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SEL_W-1:0]         sel,
   input  logic [NUM_SGI-1:0]       pend_row,
   input  logic [NUM_SGI*SRC_W-1:0] src_row,
   output logic [CODE_W-1:0]        val
);
   always_comb begin
      val = SPURIOUS;
      for (int i = 0; i < NUM_SGI; i++) begin
         if (sel == SEL_W'(i) && pend_row[i])
            val = {src_row[i*SRC_W +: SRC_W], ID_W'(i)};
      end
   end

   // R8
   spurious_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_row >> sel) & NUM_SGI'(1)) == '0 |-> val == SPURIOUS);
   // R6
   id_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_row >> sel) & NUM_SGI'(1)) != '0 |-> val[ID_W-1:0] == ID_W'(sel));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_disp_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int NUM_SGI = 16,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int SEL_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_kind,
   input  logic [CPU_W-1:0]            wr_cpu,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [31:0]                 wr_data,
   input  logic [NUM_CPU-1:0]          ack_req,
   input  logic [NUM_CPU*SEL_W-1:0]    ack_sel,
   output logic [NUM_CPU*CODE_W-1:0]   ack_val,
   output logic [NUM_CPU*NUM_SGI-1:0]  pend_out
);
   localparam int FLT_LSB  = 24;
   localparam int LIST_LSB = 16;

   initial begin
      cpu_range_chk: assert (NUM_CPU >= 1 && NUM_CPU <= 8)
         else $error("NUM_CPU must lie in 1..8");
      sgi_range_chk: assert (NUM_SGI >= 2 && NUM_SGI <= 16 && (NUM_SGI & (NUM_SGI - 1)) == 0)
         else $error("NUM_SGI must be a power of two in 2..16");
   end

   logic                     is_send, is_setb, is_clrb, id_ok;
   logic [NUM_CPU-1:0]       targets, writer_oh, bank_bits;
   logic [ID_W-1:0]          send_id;
   logic                     unused_ok;

   assign is_send   = wr_en && (op_e'(wr_kind) == OP_SEND);
   assign is_setb   = wr_en && (op_e'(wr_kind) == OP_SETB);
   assign is_clrb   = wr_en && (op_e'(wr_kind) == OP_CLRB);
   assign send_id   = wr_data[ID_W-1:0];
   assign id_ok     = send_id < ID_W'(NUM_SGI);
   assign writer_oh = NUM_CPU'(1) << wr_cpu;
   assign bank_bits = wr_data[NUM_CPU-1:0];
   assign unused_ok = ^wr_data;

   sgi_target_dec #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
      .flt     (wr_data[FLT_LSB +: 2]),
      .list    (wr_data[LIST_LSB +: NUM_CPU]),
      .writer  (wr_cpu),
      .targets (targets)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_SGI-1:0]       pend_row;
      logic [NUM_SGI*SRC_W-1:0] src_row;
      logic [SEL_W-1:0]         my_sel;
      logic                     is_writer;

      assign my_sel    = ack_sel[c*SEL_W +: SEL_W];
      assign is_writer = writer_oh[c];

      for (genvar i = 0; i < NUM_SGI; i++) begin : g_sgi
         logic send_hit, bank_hit;
         assign send_hit = is_send && id_ok && (send_id[SEL_W-1:0] == SEL_W'(i)) && targets[c];
         assign bank_hit = is_writer && (wr_sel == SEL_W'(i));

         sgi_cell #(.NUM_CPU(NUM_CPU)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (send_hit || (is_setb && bank_hit)),
            .set_bits (is_send ? writer_oh : bank_bits),
            .clr_en   (is_clrb && bank_hit),
            .clr_bits (bank_bits),
            .ack_en   (ack_req[c] && (my_sel == SEL_W'(i))),
            .pend_q   (pend_row[i]),
            .src_idx  (src_row[i*SRC_W +: SRC_W])
         );
      end

      sgi_ack_enc #(.NUM_SGI(NUM_SGI), .SEL_W(SEL_W)) u_enc (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (my_sel),
         .pend_row (pend_row),
         .src_row  (src_row),
         .val      (ack_val[c*CODE_W +: CODE_W])
      );

      assign pend_out[c*NUM_SGI +: NUM_SGI] = pend_row;
   end

   // R1
   oversize_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_send && !id_ok && ack_req == '0) |=> pend_out == $past(pend_out));
endmodule

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
   localparam int NC = 4;
   localparam int NS = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_kind = 2'd3;
   logic [1:0]        wr_cpu = '0;
   logic [3:0]        wr_sel = '0;
   logic [31:0]       wr_data = '0;
   logic [NC-1:0]     ack_req = '0;
   logic [NC*4-1:0]   ack_sel = '0;
   logic [NC*13-1:0]  ack_val;
   logic [NC*NS-1:0]  pend_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sgi_dispatch #(.NUM_CPU(NC), .NUM_SGI(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_cpu(wr_cpu),
      .wr_sel(wr_sel), .wr_data(wr_data), .ack_req(ack_req), .ack_sel(ack_sel),
      .ack_val(ack_val), .pend_out(pend_out)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [1:0]  cpu;
      logic [3:0]  sel;
      logic [31:0] data;
      logic [3:0]  areq;
      logic [1:0]  acpu;
      logic [3:0]  aid;
      logic [12:0] eack;
      logic [1:0]  ccpu;
      logic [3:0]  cid;
      logic        epend;
      logic [4:0]  req;
   } vec_t;

   // kind cpu sel data areq acpu aid eack ccpu cid epend req
   localparam vec_t VEC [23] = '{
      '{2'd0,2'd1,4'd0, 32'h0200_0003,4'b0000,2'd0,4'd0, 13'h000,2'd1,4'd3, 1'b1,5'd4},  // R4 self
      '{2'd0,2'd0,4'd0, 32'h000C_0005,4'b0000,2'd0,4'd0, 13'h000,2'd3,4'd5, 1'b1,5'd2},  // R2 list
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0000,2'd0,4'd0, 13'h000,2'd1,4'd5, 1'b0,5'd2},  // R2 unlisted
      '{2'd0,2'd2,4'd0, 32'h0100_0007,4'b0000,2'd0,4'd0, 13'h000,2'd2,4'd7, 1'b0,5'd3},  // R3 writer excluded
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0000,2'd0,4'd0, 13'h000,2'd3,4'd7, 1'b1,5'd3},  // R3 other
      '{2'd0,2'd3,4'd0, 32'h0300_0009,4'b0000,2'd0,4'd0, 13'h000,2'd3,4'd9, 1'b1,5'd4},  // R4 all
      '{2'd0,2'd1,4'd0, 32'h0001_0009,4'b0000,2'd0,4'd0, 13'h000,2'd0,4'd9, 1'b1,5'd5},  // R5 second source
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0001,2'd0,4'd9, 13'h409,2'd0,4'd9, 1'b1,5'd6},  // R6 lowest src
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0001,2'd0,4'd9, 13'hC09,2'd0,4'd9, 1'b0,5'd7},  // R7 last src
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0001,2'd0,4'd9, 13'h3FF,2'd0,4'd9, 1'b0,5'd8},  // R8 spurious
      '{2'd0,2'd0,4'd0, 32'h0300_0010,4'b0000,2'd0,4'd0, 13'h000,2'd0,4'd0, 1'b0,5'd1},  // R1 id 16
      '{2'd0,2'd0,4'd0, 32'h0300_03F0,4'b0000,2'd0,4'd0, 13'h000,2'd1,4'd0, 1'b0,5'd1},  // R1 id 0x3F0
      '{2'd2,2'd2,4'd5, 32'h0000_0001,4'b0000,2'd0,4'd0, 13'h000,2'd2,4'd5, 1'b0,5'd9},  // R9 empties
      '{2'd2,2'd3,4'd7, 32'h0000_0001,4'b0000,2'd0,4'd0, 13'h000,2'd3,4'd7, 1'b1,5'd9},  // R9 remains
      '{2'd1,2'd2,4'd11,32'h0000_0000,4'b0000,2'd0,4'd0, 13'h000,2'd2,4'd11,1'b1,5'd10}, // R10 zero data
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0100,2'd2,4'd11,13'h00B,2'd2,4'd11,1'b0,5'd10}, // R10 empty ack
      '{2'd1,2'd0,4'd4, 32'h0000_000C,4'b0000,2'd0,4'd0, 13'h000,2'd0,4'd4, 1'b1,5'd10}, // R10 bits
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0001,2'd0,4'd4, 13'h804,2'd0,4'd4, 1'b1,5'd6},  // R6 src 2
      '{2'd0,2'd1,4'd0, 32'h0001_0004,4'b0001,2'd0,4'd4, 13'hC04,2'd0,4'd4, 1'b0,5'd11}, // R11 collision
      '{2'd0,2'd1,4'd0, 32'h0200_0006,4'b1000,2'd3,4'd9, 13'hC09,2'd1,4'd6, 1'b1,5'd11}, // R11 other cell
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0000,2'd0,4'd0, 13'h000,2'd3,4'd9, 1'b0,5'd11}, // R11 ack landed
      '{2'd3,2'd0,4'd0, 32'h0,        4'b0010,2'd1,4'd6, 13'h406,2'd1,4'd6, 1'b0,5'd6},  // R6 single src
      '{2'd0,2'd0,4'd0, 32'h00F0_0002,4'b0000,2'd0,4'd0, 13'h000,2'd0,4'd2, 1'b0,5'd2}   // R2 high list bits
   };

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; wr_kind = 2'd3; wr_data = '0; ack_req = '0; ack_sel = '0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      check("R12 pend after reset", 64'(pend_out), 64'h0);
      @(negedge clk) rst_n = 1'b1;
      #1 check("R12 ack_val after reset", 64'(ack_val), 64'({4{13'h3FF}}));

      for (int v = 0; v < 23; v++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_kind = VEC[v].kind;
         wr_cpu  = VEC[v].cpu;
         wr_sel  = VEC[v].sel;
         wr_data = VEC[v].data;
         ack_req = VEC[v].areq;
         ack_sel = {4{VEC[v].aid}};
         #1;
         if (VEC[v].areq != '0)
            check($sformatf("R%0d vec %0d ack_val", VEC[v].req, v),
                  64'(ack_val[VEC[v].acpu*13 +: 13]), 64'(VEC[v].eack));
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec %0d pend", VEC[v].req, v),
               64'(pend_out[VEC[v].ccpu*NS + VEC[v].cid]), 64'(VEC[v].epend));
         @(negedge clk) idle_inputs();
      end

      // R5/R11: broadcast from core 3, then all cores acknowledge together
      @(negedge clk);
      wr_en = 1'b1; wr_kind = 2'd0; wr_cpu = 2'd3; wr_data = 32'h0300_000F;
      @(negedge clk);
      idle_inputs();
      ack_req = 4'b1111; ack_sel = {4{4'd15}};
      #1 check("R11 parallel ack codes", 64'(ack_val), 64'({4{13'hC0F}}));
      @(negedge clk);
      idle_inputs();
      #1 check("R7 parallel ack drops pending", 64'(pend_out & 64'hF000_F000_F000_F000), 64'h0);

      // R12 reset during activity
      @(negedge clk);
      wr_en = 1'b1; wr_kind = 2'd0; wr_cpu = 2'd0; wr_data = 32'h0300_0001;
      @(negedge clk);
      idle_inputs();
      #1 check("R4 all before reset", 64'(pend_out & 64'h0002_0002_0002_0002), 64'h0002_0002_0002_0002);
      rst_n = 1'b0;
      @(negedge clk);
      #1 check("R12 pend cleared by reset", 64'(pend_out), 64'h0);
      rst_n = 1'b1;

      finish_run();
   end
endmodule